// File: doc/BRIEF.md
# Frame Command Executor with Bus Master

This block sits between a frame receive path that has already removed the security wrapping from a configuration frame and the chip's internal register bus. Each frame carries exactly one command: a register read or a register write. The block takes that command, runs one Wishbone-style master cycle on the internal bus, and waits for it to finish. It then presents a plaintext response to the transmit path, which builds and encrypts the reply frame from it.

A read command carries a 16-bit register address. Its response returns the 32-bit value the bus slave gave back, so that a remote manager can compare it with data written earlier. A write command carries a 16-bit address and a 32-bit data word. Its response echoes both, together with a status byte. Opcodes that are not recognised, slave errors and silent slaves each end in a response with its own status code. The bus is never left stuck: a cycle that gets no answer within a fixed number of clocks is closed.

Only one command is in flight at a time. The command side is refused from the moment a command is taken until the transmit path has consumed its response.

Top module: `cfg_cmd_exec`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `cmd_ready` is 1 and `wb_cyc`, `wb_stb` and `rsp_valid` are 0.
- R2: A command accepted with opcode 8'h52 (read) starts a bus cycle in the next clock: `wb_cyc`=`wb_stb`=1, `wb_we`=0 and `wb_adr` equal to the command address.
- R3: A command accepted with opcode 8'h57 (write) starts a bus cycle in the next clock with `wb_we`=1, `wb_adr` equal to the command address and `wb_dat_o` equal to the command data.
- R4: Once started, a bus cycle keeps `wb_cyc`, `wb_stb`, `wb_we`, `wb_adr` and `wb_dat_o` unchanged until a clock in which `wb_ack` or `wb_err` is high, or until the timeout ends it. It drops in the clock after that.
- R5: A read that ends on `wb_ack` produces a response with status 8'h00 and `rsp_data` equal to `wb_dat_i` in the ack clock.
- R6: Every response echoes the opcode in `rsp_op` and the address in `rsp_addr`. A write response carries the written data in `rsp_data`, whatever its status.
- R7: A cycle that sees `wb_err` ends with status 8'h01, and `wb_err` wins when it is high together with `wb_ack`. For a read, `rsp_data` is 0.
- R8: A cycle that sees neither ack nor err ends after exactly TIMEOUT clocks with `wb_cyc` high (default 256), with status 8'h02. For a read, `rsp_data` is 0.
- R9: Any opcode other than 8'h52 or 8'h57 produces a response in the next clock with status 8'h03 and `rsp_data` 0, and no bus cycle is started.
- R10: `cmd_ready` is 0 from the clock after a command is accepted until the clock after its response is consumed. `cmd_valid` has no effect while `cmd_ready` is 0.
- R11: `rsp_valid` and all response fields hold steady until a clock in which `rsp_ready` is high. The block is ready for a new command in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decrypted command is offered |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 32 | Write data (ignored for reads) |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 16 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus cycle acknowledged |
| wb_err | input | 1 | Bus cycle failed |
| rsp_valid | output | 1 | Response ready for the transmit path |
| rsp_ready | input | 1 | Transmit path takes the response |
| rsp_op | output | 8 | Echoed opcode |
| rsp_status | output | 8 | 00 ok, 01 bus error, 02 timeout, 03 bad opcode |
| rsp_addr | output | 16 | Echoed address |
| rsp_data | output | 32 | Read data or echoed write data |

## Verification
The assertions assume that the bus slave only raises `wb_ack` or `wb_err` while `wb_cyc` is high. They also assume that `rsp_ready` and the command inputs change only between clock edges. The bench's slave model samples `wb_cyc` after each edge and drives ack or err for one clock only while a cycle is open. Its command and response drivers change inputs only at the falling edge, and they keep `cmd_valid` raised through busy periods so that the ignore rule is actually tested.

// File: rtl/cfg_cmd_pkg.sv
// Shared constants and types for the frame command executor.
// Assumes 8-bit opcodes and 8-bit status codes as seen by the frame paths.
package cfg_cmd_pkg;
    localparam logic [7:0] OP_READ  = 8'h52;
    localparam logic [7:0] OP_WRITE = 8'h57;

    localparam logic [7:0] ST_OK     = 8'h00;
    localparam logic [7:0] ST_BUSERR = 8'h01;
    localparam logic [7:0] ST_TMO    = 8'h02;
    localparam logic [7:0] ST_BADOP  = 8'h03;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_BUS  = 2'd1,
        EX_RESP = 2'd2
    } exec_state_e;
endpackage

// File: rtl/cfg_cmd_decode.sv
// Opcode classifier: tells read, write and unknown opcodes apart.
// Pure combinational; assumes the opcode is stable while it is examined.
module cfg_cmd_decode
    import cfg_cmd_pkg::*;
(
    input  logic [7:0] op,
    output logic       is_read,
    output logic       is_write,
    output logic       is_known
);
    // Match the two supported opcodes.
    always_comb begin
        is_read  = (op == OP_READ);
        is_write = (op == OP_WRITE);
        is_known = is_read || is_write;
    end
endmodule

// File: rtl/cfg_bus_timer.sv
// Bus watchdog: counts clocks while a cycle runs and flags the last allowed one.
// Assumes run stays high for the whole cycle; the count clears when run drops.
module cfg_bus_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    // Count clocks spent in the current bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final clock the cycle may stay open.
    always_comb expire = run && (cnt == LAST);
endmodule

// File: rtl/cfg_cmd_exec.sv
// Frame command executor: takes one read or write command, runs a single
// bus master cycle, and holds a plaintext response until it is consumed.
// Assumes the slave answers with ack or err only while cyc is high; a cycle
// with no answer is closed after TIMEOUT clocks.
module cfg_cmd_exec
    import cfg_cmd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [ADDR_W-1:0] wb_adr,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack,
    input  logic              wb_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [7:0]        rsp_op,
    output logic [7:0]        rsp_status,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data
);
    exec_state_e       state;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] wd_q;
    logic              we_q;
    logic [7:0]        status_q;
    logic [DATA_W-1:0] data_q;

    logic dec_read, dec_write, dec_known;
    logic tmo_expire;
    logic [7:0]        end_status;
    logic [DATA_W-1:0] end_data;
    logic              bus_done;

    cfg_cmd_decode u_decode (
        .op       (cmd_op),
        .is_read  (dec_read),
        .is_write (dec_write),
        .is_known (dec_known)
    );

    cfg_bus_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == EX_BUS),
        .expire (tmo_expire)
    );

    // Pick the outcome of the bus cycle: err beats ack, ack beats timeout.
    always_comb begin
        bus_done   = wb_err || wb_ack || tmo_expire;
        end_status = ST_OK;
        end_data   = we_q ? wd_q : '0;
        if (wb_err) begin
            end_status = ST_BUSERR;
        end else if (wb_ack) begin
            end_status = ST_OK;
            end_data   = we_q ? wd_q : wb_dat_i;
        end else if (tmo_expire) begin
            end_status = ST_TMO;
        end
    end

    // Command acceptance, bus cycle tracking and response holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= EX_IDLE;
            op_q     <= '0;
            adr_q    <= '0;
            wd_q     <= '0;
            we_q     <= 1'b0;
            status_q <= ST_OK;
            data_q   <= '0;
        end else begin
            case (state)
                EX_IDLE: begin
                    if (cmd_valid) begin
                        op_q  <= cmd_op;
                        adr_q <= cmd_addr;
                        wd_q  <= cmd_wdata;
                        we_q  <= dec_write && !dec_read;
                        if (dec_known) begin
                            state <= EX_BUS;
                        end else begin
                            status_q <= ST_BADOP;
                            data_q   <= '0;
                            state    <= EX_RESP;
                        end
                    end
                end
                EX_BUS: begin
                    if (bus_done) begin
                        status_q <= end_status;
                        data_q   <= end_data;
                        state    <= EX_RESP;
                    end
                end
                EX_RESP: begin
                    if (rsp_ready) begin
                        state <= EX_IDLE;
                    end
                end
                default: state <= EX_IDLE;
            endcase
        end
    end

    // Drive bus and response ports from the held command.
    always_comb begin
        cmd_ready  = (state == EX_IDLE);
        wb_cyc     = (state == EX_BUS);
        wb_stb     = (state == EX_BUS);
        wb_we      = we_q;
        wb_adr     = adr_q;
        wb_dat_o   = wd_q;
        rsp_valid  = (state == EX_RESP);
        rsp_op     = op_q;
        rsp_status = status_q;
        rsp_addr   = adr_q;
        rsp_data   = data_q;
    end
endmodule

// File: rtl/cfg_cmd_exec_chk.sv
// Property checker for the frame command executor, attached by bind.
// Assumes ack/err are only raised while cyc is high.
module cfg_cmd_exec_chk
    import cfg_cmd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic [DATA_W-1:0] wb_dat_i,
    input logic              wb_ack,
    input logic              wb_err,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [7:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_data
);
    int cyc_len;

    // Length of the open bus cycle, counted here instead of a deep $past.
    always_ff @(posedge clk) begin
        if (!rst_n || !wb_cyc) cyc_len <= 0;
        else                   cyc_len <= cyc_len + 1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !wb_cyc && !wb_stb && !rsp_valid));

    a_r2_read_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_READ) |=>
        (wb_cyc && wb_stb && !wb_we && wb_adr == $past(cmd_addr)));

    a_r3_write_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_WRITE) |=>
        (wb_cyc && wb_stb && wb_we && wb_adr == $past(cmd_addr)
         && wb_dat_o == $past(cmd_wdata)));

    a_r4_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && !wb_ack && !wb_err && cyc_len < TIMEOUT - 1) |=>
        (wb_cyc && wb_stb && $stable(wb_we) && $stable(wb_adr) && $stable(wb_dat_o)));

    a_r4_close_on_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && (wb_ack || wb_err)) |=> (!wb_cyc && rsp_valid));

    a_r5_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_ack && !wb_err && !wb_we) |=>
        (rsp_status == ST_OK && rsp_data == $past(wb_dat_i)));

    a_r7_err_status: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_err) |=> (rsp_status == ST_BUSERR));

    a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> (cyc_len < TIMEOUT));

    a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && !wb_ack && !wb_err && cyc_len == TIMEOUT - 1) |=>
        (!wb_cyc && rsp_valid && rsp_status == ST_TMO));

    a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op != OP_READ && cmd_op != OP_WRITE) |=>
        (!wb_cyc && rsp_valid && rsp_status == ST_BADOP));

    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc || rsp_valid) |-> !cmd_ready);

    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_status) && $stable(rsp_data)));
endmodule

bind cfg_cmd_exec cfg_cmd_exec_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIMEOUT(TIMEOUT)
) u_chk (.*);

// File: tb/cfg_cmd_exec_bench.sv
// Bench: behavioural reference model compared on every clock, plus a slave model.
module cfg_cmd_exec_bench;
    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_op = 8'h00;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_wdata = '0;
    logic        wb_cyc, wb_stb, wb_we;
    logic [15:0] wb_adr;
    logic [31:0] wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack = 1'b0;
    logic        wb_err = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [7:0]  rsp_op, rsp_status;
    logic [15:0] rsp_addr;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Slave model controls: 0 ack, 1 err, 2 silent, 3 ack+err.
    int slv_mode = 0;
    int slv_delay = 0;
    int slv_wait = 0;
    logic [31:0] slv_mem [16];

    // Reference model state: 0 idle, 1 bus, 2 response.
    int          m_st = 0;
    int          m_cnt = 0;
    logic [7:0]  m_op, m_stat;
    logic [15:0] m_adr;
    logic [31:0] m_wd, m_data;
    bit          m_we;

    always #4 clk = ~clk;

    cfg_cmd_exec #(.TIMEOUT(TMO)) u_cfg_cmd_exec (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (cmd_valid) begin
                    m_op = cmd_op; m_adr = cmd_addr; m_wd = cmd_wdata;
                    m_we = (cmd_op == 8'h57);
                    if (cmd_op == 8'h52 || cmd_op == 8'h57) begin
                        m_st = 1; m_cnt = 0;
                    end else begin
                        m_st = 2; m_stat = 8'h03; m_data = 0;
                    end
                end
                1: begin
                    if (wb_err) begin
                        m_st = 2; m_stat = 8'h01; m_data = m_we ? m_wd : 0;
                    end else if (wb_ack) begin
                        m_st = 2; m_stat = 8'h00; m_data = m_we ? m_wd : wb_dat_i;
                    end else if (m_cnt == TMO - 1) begin
                        m_st = 2; m_stat = 8'h02; m_data = m_we ? m_wd : 0;
                    end else begin
                        m_cnt++;
                    end
                end
                default: if (rsp_ready) m_st = 0;
            endcase
        end
    end

    // Compare on each falling edge, then advance the slave model.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 cmd_ready", cmd_ready, m_st == 0);
            check("R4 wb_cyc", wb_cyc, m_st == 1);
            check("R4 wb_stb", wb_stb, m_st == 1);
            check("R11 rsp_valid", rsp_valid, m_st == 2);
            if (m_st == 1) begin
                check("R2 wb_we", wb_we, m_we);
                check("R2 wb_adr", wb_adr, m_adr);
                if (m_we) check("R3 wb_dat_o", wb_dat_o, m_wd);
            end
            if (m_st == 2) begin
                check("R6 rsp_op", rsp_op, m_op);
                check("R6 rsp_addr", rsp_addr, m_adr);
                check("R7 rsp_status", rsp_status, m_stat);
                check("R5 rsp_data", rsp_data, m_data);
            end
        end
        wb_ack = 1'b0;
        wb_err = 1'b0;
        if (wb_cyc) begin
            if (slv_wait == slv_delay) begin
                case (slv_mode)
                    0: begin
                        wb_ack = 1'b1;
                        if (wb_we) slv_mem[wb_adr[3:0]] = wb_dat_o;
                        wb_dat_i = slv_mem[wb_adr[3:0]];
                    end
                    1: wb_err = 1'b1;
                    3: begin wb_ack = 1'b1; wb_err = 1'b1; end
                    default: ;
                endcase
            end
            slv_wait++;
        end else begin
            slv_wait = 0;
        end
    end

    // Offer one command, hold it through busy clocks, wait for its response.
    task automatic run_cmd(input logic [7:0] op, input logic [15:0] adr, input logic [31:0] wd,
                           input string req, input logic [7:0] exp_st, input logic [31:0] exp_d,
                           input int hold_rsp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = adr; cmd_wdata = wd;
        rsp_ready = (hold_rsp == 0);
        @(negedge clk);
        // Keep valid high with other content while busy: must be ignored (R10).
        cmd_op = 8'h57; cmd_addr = 16'hFFFF; cmd_wdata = 32'hDEAD_BEEF;
        while (!rsp_valid && !done) @(negedge clk);
        cmd_valid = 1'b0;
        check({req, " status"}, rsp_status, exp_st);
        check({req, " data"}, rsp_data, exp_d);
        check("R6 addr echo", rsp_addr, adr);
        if (hold_rsp > 0) begin
            repeat (hold_rsp) @(negedge clk);
            check("R11 held", rsp_valid, 1'b1);
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        rsp_ready = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) slv_mem[i] = 32'h1000_0000 + i;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", cmd_ready, 1'b1);
        check("R1 cyc in reset", wb_cyc, 1'b0);
        check("R1 rsp in reset", rsp_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {cmd_ready, wb_cyc, rsp_valid}, 3'b100);

        slv_mode = 0; slv_delay = 0;
        run_cmd(8'h57, 16'h0003, 32'hA5A5_0001, "R3 write", 8'h00, 32'hA5A5_0001, 0);
        slv_delay = 3;
        run_cmd(8'h52, 16'h0003, 32'h0, "R5 readback", 8'h00, 32'hA5A5_0001, 0);
        run_cmd(8'h57, 16'h0007, 32'h0BAD_F00D, "R6 write echo", 8'h00, 32'h0BAD_F00D, 4);
        slv_delay = 0;
        run_cmd(8'h52, 16'h0007, 32'h0, "R2 read", 8'h00, 32'h0BAD_F00D, 0);
        run_cmd(8'h52, 16'h0005, 32'h0, "R5 read init", 8'h00, 32'h1000_0005, 0);
        run_cmd(8'h41, 16'h0002, 32'h1234_5678, "R9 bad op", 8'h03, 32'h0, 0);
        run_cmd(8'h00, 16'h0009, 32'h0, "R9 zero op", 8'h03, 32'h0, 2);
        slv_mode = 1; slv_delay = 2;
        run_cmd(8'h57, 16'h0004, 32'h5555_AAAA, "R7 write err", 8'h01, 32'h5555_AAAA, 0);
        run_cmd(8'h52, 16'h0004, 32'h0, "R7 read err", 8'h01, 32'h0, 0);
        slv_mode = 3; slv_delay = 1;
        run_cmd(8'h52, 16'h0003, 32'h0, "R7 err over ack", 8'h01, 32'h0, 0);
        slv_mode = 2;
        run_cmd(8'h52, 16'h0003, 32'h0, "R8 read timeout", 8'h02, 32'h0, 0);
        run_cmd(8'h57, 16'h0006, 32'h7777_0000, "R8 write timeout", 8'h02, 32'h7777_0000, 0);
        slv_mode = 0; slv_delay = 0;
        run_cmd(8'h52, 16'h0006, 32'h0, "R8 no store after timeout", 8'h00, 32'h1000_0006, 0);
        run_cmd(8'h52, 16'h0004, 32'h0, "R7 no store after err", 8'h00, 32'h1000_0004, 0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule